// File: doc/BRIEF.md
# Shared Legacy Interrupt Pin Aggregator

This block merges the level-sensitive legacy interrupt pins of a set of PCI device slots onto four shared bus interrupt lines. Each device has four pins, encoded 0 (INTA), 1 (INTB), 2 (INTC) and 3 (INTD). A device reports a change through a single event port that carries its device/function number, the pin and the new level. The block rotates the pin by the device's slot so that devices in neighbouring slots spread across the four lines. It then keeps a per-line count of the devices currently driving that line, so the line behaves as a wired-OR of every device mapped onto it.

A parameter picks the mapping variant: plain slot rotation, rotation with the slot reduced by one, or no rotation at all. The block remembers the last level recorded for each slot and each line. Each event therefore moves a count only by the difference between the new level and the remembered one. A device that repeats its state, or that releases a pin it never raised, leaves the lines untouched. Routing the four lines to a system interrupt controller happens outside this block.

Top module: `intx_share_agg`

## Requirements
- R1: The slot is the device/function number shifted right by three bits. The three function bits take no part in the mapping or in the per-slot record, so events from any function of one slot act on the same record.
- R2: With MAP_MODE 0, an event on pin p from slot s drives bus line (p + s) mod 4, taken as the low two bits of the sum. Bit n of `bus_irq` is line n.
- R3: With MAP_MODE 1, the line is (p + s - 1) mod 4, so slot 0 pin 0 maps to line 3.
- R4: With MAP_MODE 2, the line equals the pin index, whatever the slot.
- R5: An accepted event changes its line's count by the new level minus the level previously recorded for that slot and line, and then records the new level. A line output is high exactly while its count is nonzero, so it stays high until the last device driving it releases it.
- R6: An event whose level equals the recorded level leaves every count and every output unchanged. This includes a release of a pin that was never raised.
- R7: Reset clears every recorded level and every count, so all outputs are low after reset, and a release that follows reset does not underflow a count.
- R8: Counts hold all NUM_SLOTS devices driving one line at once without overflow. The line stays high until every one of those devices has released it.
- R9: An event whose slot is NUM_SLOTS or above is ignored, and no record or count changes.
- R10: At most one event is taken per clock, when `ev_valid` is high at a rising edge. Outputs keep their old value before that edge and show the result after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event present this cycle |
| ev_devfn | input | DEVFN_W | Device/function number of the reporting device |
| ev_pin | input | 2 | Device pin, 0=INTA to 3=INTD |
| ev_level | input | 1 | New level of that pin |
| bus_irq | output | 4 | Shared bus interrupt lines, bit n is line n |

## Verification
The hardest condition to reach from the ports is a line count at its maximum, with every slot driving the same line. Only a port-visible output is available, and that output cannot tell a count of one from a count of eight. The bench works out, for each slot, the pin that lands on line 0 under rotation and raises all of them. It then releases the slots one at a time and checks that the line stays high until the very last release. Three instances, one per mapping mode, receive the same event stream and are compared against a model of the requirements. An out-of-range slot number is sent whose low bits alias slot 0, so a missing range check would show up on the outputs.

// File: rtl/intx_share_agg.sv
module intx_share_agg #(
  parameter int NUM_SLOTS = 8,
  parameter int DEVFN_W   = 8,
  parameter int MAP_MODE  = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ev_valid,
  input  logic [DEVFN_W-1:0] ev_devfn,
  input  logic [1:0]         ev_pin,
  input  logic               ev_level,
  output logic [3:0]         bus_irq
);
  localparam int SLOT_W = DEVFN_W - 3;
  localparam int IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int CNT_W  = $clog2(NUM_SLOTS + 1);

  logic [SLOT_W-1:0]           ev_slot;
  logic [IDX_W-1:0]            slot_idx;
  logic                        slot_ok;
  logic [1:0]                  line;
  logic                        prev_lvl;
  logic                        take;
  logic [DEPTH-1:0][3:0]       rec;
  logic [3:0][CNT_W-1:0]       cnt;

  assign ev_slot  = ev_devfn[DEVFN_W-1:3];
  assign slot_idx = ev_slot[IDX_W-1:0];
  assign slot_ok  = 32'(ev_slot) < 32'(NUM_SLOTS);

  generate
    if (MAP_MODE == 2) begin : g_ident
      assign line = ev_pin;
    end else if (MAP_MODE == 1) begin : g_rot_m1
      assign line = ev_pin + ev_slot[1:0] - 2'd1;
    end else begin : g_rot
      assign line = ev_pin + ev_slot[1:0];
    end
  endgenerate

  assign prev_lvl = rec[slot_idx][line];
  assign take     = ev_valid && slot_ok && (ev_level != prev_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec <= '0;
      cnt <= '0;
    end else if (take) begin
      rec[slot_idx][line] <= ev_level;
      cnt[line] <= ev_level ? cnt[line] + CNT_W'(1) : cnt[line] - CNT_W'(1);
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_line
    assign bus_irq[l] = |cnt[l];

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      32'(cnt[l]) <= 32'(NUM_SLOTS));
  end

  assert_same_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && slot_ok && ev_level == prev_lvl) |=> $stable(cnt) && $stable(rec));

  assert_ignore_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !slot_ok) |=> $stable(cnt) && $stable(rec));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> $stable(bus_irq));

  assert_reset_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (bus_irq == 4'b0000));

endmodule

// File: tb/intx_share_agg_tb.sv
`timescale 1ns/1ps
module intx_share_agg_tb_top;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       ev_valid = 0;
  logic [7:0] ev_devfn = 0;
  logic [1:0] ev_pin = 0;
  logic       ev_level = 0;
  logic [3:0] out0, out1, out2;
  int checks = 0, fails = 0;

  bit exp_rec [3][32][4];
  int exp_cnt [3][4];

  always #10 clk = ~clk;

  intx_share_agg #(.NUM_SLOTS(8), .DEVFN_W(8), .MAP_MODE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_devfn(ev_devfn),
    .ev_pin(ev_pin), .ev_level(ev_level), .bus_irq(out0));
  intx_share_agg #(.NUM_SLOTS(8), .DEVFN_W(8), .MAP_MODE(1)) dut_m1 (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_devfn(ev_devfn),
    .ev_pin(ev_pin), .ev_level(ev_level), .bus_irq(out1));
  intx_share_agg #(.NUM_SLOTS(8), .DEVFN_W(8), .MAP_MODE(2)) dut_id (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_devfn(ev_devfn),
    .ev_pin(ev_pin), .ev_level(ev_level), .bus_irq(out2));

  function automatic int map_line(int mode, int devfn, int pin);
    int s = devfn >> 3;
    if (mode == 2) return pin;
    return (pin + s - ((mode == 1) ? 1 : 0)) & 3;
  endfunction

  function automatic logic [3:0] exp_vec(int mode);
    logic [3:0] v;
    for (int l = 0; l < 4; l++) v[l] = (exp_cnt[mode][l] != 0);
    return v;
  endfunction

  task automatic model_clear();
    for (int m = 0; m < 3; m++)
      for (int l = 0; l < 4; l++) begin
        exp_cnt[m][l] = 0;
        for (int s = 0; s < 32; s++) exp_rec[m][s][l] = 0;
      end
  endtask

  task automatic model_apply(int devfn, int pin, bit lvl);
    int s = devfn >> 3;
    if (s >= 8) return;
    for (int m = 0; m < 3; m++) begin
      int l = map_line(m, devfn, pin);
      if (exp_rec[m][s][l] != lvl) begin
        exp_cnt[m][l] += lvl ? 1 : -1;
        exp_rec[m][s][l] = lvl;
      end
    end
  endtask

  task automatic check(string tag);
    logic [3:0] act [3];
    act[0] = out0; act[1] = out1; act[2] = out2;
    for (int m = 0; m < 3; m++) begin
      checks++;
      if (act[m] !== exp_vec(m)) begin
        fails++;
        $display("FAIL %s mode%0d bus_irq actual=%b expected=%b", tag, m, act[m], exp_vec(m));
      end
    end
  endtask

  task automatic send(int devfn, int pin, bit lvl);
    @(negedge clk);
    ev_valid = 1; ev_devfn = 8'(devfn); ev_pin = 2'(pin); ev_level = lvl;
    @(negedge clk);
    ev_valid = 0;
    model_apply(devfn, pin, lvl);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    model_clear();
  endtask

  task automatic t_rotation();
    send(8, 0, 1);  check("R2 R3 R4 slot1 pinA");
    send(8, 0, 0);
    send(0, 0, 1);  check("R3 slot0 pinA wraps to line3");
    send(0, 0, 0);
    send(24, 2, 1); check("R2 R3 R4 slot3 pinC");
    send(24, 2, 0); check("R5 release clears");
  endtask

  task automatic t_function_bits();
    send(16 + 5, 1, 1); check("R1 func5 raises");
    send(16 + 0, 1, 0); check("R1 func0 releases same record");
  endtask

  task automatic t_sharing();
    send(8, 3, 1); send(16, 2, 1); check("R5 two devices share line0");
    send(8, 3, 0); check("R5 line held by remaining device");
    send(16, 2, 0); check("R5 last release drops line");
  endtask

  task automatic t_repeat();
    send(40, 1, 1); send(40, 1, 1); send(40, 1, 0); check("r6_repeat raise counted once");
    send(48, 2, 0); check("R6 release of unraised pin");
    send(56, 0, 1); send(56, 0, 0); check("R6 no underflow after spurious release");
  endtask

  task automatic t_out_of_range();
    send(64, 0, 1);  check("R9 slot8 ignored");
    send(0, 0, 1);   send(64, 0, 0); check("R9 slot8 release does not alias slot0");
    send(0, 0, 0);
  endtask

  task automatic t_all_slots();
    for (int s = 0; s < 8; s++) send(s * 8, (4 - (s & 3)) & 3, 1);
    check("R8 all slots raised");
    for (int s = 0; s < 7; s++) send(s * 8, (4 - (s & 3)) & 3, 0);
    check("R8 line0 held by last slot");
    send(56, (4 - 3) & 3, 0); check("R8 all released");
  endtask

  task automatic t_timing();
    @(negedge clk);
    ev_valid = 1; ev_devfn = 8'd8; ev_pin = 2'd1; ev_level = 1;
    #2 check("R10 before edge unchanged");
    @(negedge clk); ev_valid = 0;
    model_apply(8, 1, 1);
    check("R10 after edge updated");
  endtask

  task automatic t_reset_mid();
    send(32, 3, 1);
    do_reset(); check("R7 reset clears lines");
    send(32, 3, 0); check("R7 stale release after reset");
    send(32, 3, 1); check("R7 raise after reset");
    send(32, 3, 0);
  endtask

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R7 reset state");
    rst_n = 1;
    @(negedge clk);
    check("R7 after release");
    t_rotation();
    t_function_bits();
    t_sharing();
    t_repeat();
    t_out_of_range();
    t_all_slots();
    t_timing();
    t_reset_mid();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule